// File: doc/BRIEF.md
# ONFI Probe and Parameter Page Sequencer

This block brings up an unknown NAND device on a byte-wide command/address/data bus. On a start pulse it issues a device reset, polls the status register until the device reports ready and passed, reads the four-byte ONFI signature through the read-ID command, and then fetches the parameter page. While the page streams in, the geometry fields are picked out at fixed byte positions and assembled little-endian into shadow registers. The visible field outputs change only when the whole probe succeeds.

The sequencer is built around one state machine. Its states are S_IDLE, S_RESET, S_PROBE, S_SIG_CMD, S_SIG_ADDR, S_SIG_READ, S_PRM_CMD, S_PRM_ADDR, S_PRM_WAIT, S_PRM_DOUT, S_PRM_READ, S_CHECK and S_FINISH. The path runs as follows:
- S_IDLE moves to S_RESET on start.
- S_RESET moves to S_PROBE and launches a status poll.
- S_PROBE stays put, relaunching the poll after each failed attempt. It goes to S_SIG_CMD on a passing poll, or to S_FINISH with "no device" after the last allowed attempt fails.
- S_SIG_CMD, S_SIG_ADDR and S_SIG_READ run in sequence. From S_SIG_READ the machine goes to S_PRM_CMD if the signature matches, or to S_FINISH with "no device" if it does not.
- S_PRM_CMD, S_PRM_ADDR (which launches a poll), S_PRM_WAIT (which waits for the poll to end), S_PRM_DOUT, S_PRM_READ and S_CHECK follow in order.
- S_CHECK moves to S_FINISH. S_FINISH returns to S_IDLE.

A small status-poll engine runs in its own four states: P_IDLE, P_CMD, P_READ and P_DONE. It owns the bus while it runs.

Top module: `onfi_probe`

## Requirements
- R1: After reset, busy, done and found are 0, err_code is 00, every field output is zero, and no bus strobe is active while the block is idle.
- R2: In any cycle, at most one bus operation takes place. nand_cle or nand_ale is asserted only together with nand_we, never both of them at once, and nand_we and nand_re are never asserted together.
- R3: A start pulse in idle produces exactly one reset command (0xFF). A status poll follows it: command 0x70, then status reads. Status bit 6 set means ready, and status bit 0 set means the last operation failed.
- R4: A poll attempt passes only when a read shows bit 6 = 1 and bit 0 = 0. If PROBE_TRIES attempts (default 60) all fail, the result is err_code 01 (no device) with found = 0, and no read-ID command (0x90) is issued.
- R5: A failed attempt, whether the device reported ready with fail set or the poll timed out, is followed by a fresh attempt. A pass on the last allowed attempt still continues the probe.
- R6: The signature check writes command 0x90, then address 0x20, then reads four bytes. These must equal 0x4F, 0x4E, 0x46, 0x49 in order. Any mismatch ends the probe with err_code 01 and no parameter command.
- R7: The parameter fetch writes command 0xEC and address 0x00, performs one status poll (its result is not judged), writes command 0x00, and then performs exactly PARAM_BYTES (default 116) reads.
- R8: If every parameter byte reads 0xFF, the result is err_code 10 (I/O error) with found = 0. The field outputs keep their previous values.
- R9: On success, the fields are taken from the page at byte offsets counted from 0:
  - bus_x16 from bit 0 of byte 6
  - model_code from byte 49
  - mfr_id from byte 64
  - page_bytes from bytes 80..83
  - spare_bytes from bytes 84..85
  - pages_per_blk from bytes 92..95
  - blks_per_lun from bytes 96..99
  - lun_count from byte 100
  - ecc_bits from byte 112

  Multi-byte fields are little-endian, with the lowest offset as the least significant byte.
- R10: When a probe ends, done is high for exactly one cycle. err_code and found are valid from that cycle until the next probe ends. On success, err_code is 00 and found is 1.
- R11: A start pulse received while busy is ignored, so the running probe issues no second reset command.
- R12: A single poll attempt performs at most POLL_READS status reads (default 64) before it gives up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a probe (honoured only when idle) |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle pulse when a probe ends |
| found | output | 1 | Last probe succeeded |
| err_code | output | 2 | 00 ok, 01 no device, 10 I/O error |
| nand_cle | output | 1 | Qualifies a write as a command byte |
| nand_ale | output | 1 | Qualifies a write as an address byte |
| nand_we | output | 1 | Write strobe for nand_dout |
| nand_re | output | 1 | Read strobe; nand_din is sampled in the same cycle |
| nand_dout | output | 8 | Byte written to the device |
| nand_din | input | 8 | Byte returned by the device |
| mfr_id | output | 8 | Manufacturer code |
| bus_x16 | output | 1 | Device bus is 16 bits wide |
| page_bytes | output | 32 | Data bytes per page |
| spare_bytes | output | 16 | Spare bytes per page |
| pages_per_blk | output | 32 | Pages per erase block |
| blks_per_lun | output | 32 | Blocks per logical unit |
| lun_count | output | 8 | Number of logical units |
| ecc_bits | output | 8 | Required ECC correction bits |
| model_code | output | 8 | Model byte |

## Verification
The bench targets the poll boundaries. These are a pass on exactly the last allowed attempt, all attempts failing, a device that never becomes ready, and a ready bit that appears on the last permitted read. An off-by-one in the attempt or read counter would turn a valid device into "no device", or would spin one attempt too many. A corrupted signature byte and an all-0xFF page must leave the previously captured fields untouched; a design that commits its shadow registers early would overwrite them. Distinct byte values in every field expose swapped byte order or shifted offsets. A start pulse in the middle of a probe would show up as a second reset command.

// File: rtl/onfi_probe_pkg.sv
package onfi_probe_pkg;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'b00,
        ERR_NODEV = 2'b01,
        ERR_IO    = 2'b10
    } probe_err_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RESET,
        S_PROBE,
        S_SIG_CMD,
        S_SIG_ADDR,
        S_SIG_READ,
        S_PRM_CMD,
        S_PRM_ADDR,
        S_PRM_WAIT,
        S_PRM_DOUT,
        S_PRM_READ,
        S_CHECK,
        S_FINISH
    } seq_state_e;

    typedef enum logic [1:0] {
        P_IDLE,
        P_CMD,
        P_READ,
        P_DONE
    } poll_state_e;

    // Device opcodes and fixed addresses
    localparam logic [7:0] OP_RESET    = 8'hFF;
    localparam logic [7:0] OP_STATUS   = 8'h70;
    localparam logic [7:0] OP_READ_ID  = 8'h90;
    localparam logic [7:0] OP_PARAM    = 8'hEC;
    localparam logic [7:0] OP_DATA_OUT = 8'h00;
    localparam logic [7:0] ADDR_SIG    = 8'h20;
    localparam logic [7:0] ADDR_PARAM  = 8'h00;

    // Status byte bits
    localparam int STAT_READY_BIT = 6;
    localparam int STAT_FAIL_BIT  = 0;

    // Parameter page byte offsets (device-defined layout)
    localparam int OFF_WIDTH = 6;
    localparam int OFF_MODEL = 49;
    localparam int OFF_MFR   = 64;
    localparam int OFF_PAGE  = 80;
    localparam int OFF_SPARE = 84;
    localparam int OFF_PPB   = 92;
    localparam int OFF_BPL   = 96;
    localparam int OFF_LUNS  = 100;
    localparam int OFF_ECC   = 112;

    function automatic logic [7:0] sig_char(input logic [1:0] pos);
        unique case (pos)
            2'd0: sig_char = 8'h4F;
            2'd1: sig_char = 8'h4E;
            2'd2: sig_char = 8'h46;
            default: sig_char = 8'h49;
        endcase
    endfunction

endpackage

// File: rtl/onfi_status_poll.sv
module onfi_status_poll
    import onfi_probe_pkg::*;
#(
    parameter int POLL_READS = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       stat_ready,
    input  logic       stat_fail,
    output logic       owns_bus,
    output logic       cmd_we,
    output logic       rd_en,
    output logic [7:0] cmd_byte,
    output logic       done,
    output logic       pass
);

    localparam int CNT_W = $clog2(POLL_READS + 1);
    localparam logic [CNT_W-1:0] LAST_READ = CNT_W'(POLL_READS - 1);

    poll_state_e      pstate;
    logic [CNT_W-1:0] rd_cnt;
    logic             pass_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pstate <= P_IDLE;
            rd_cnt <= '0;
            pass_q <= 1'b0;
        end else begin
            unique case (pstate)
                P_IDLE: begin
                    if (go) pstate <= P_CMD;
                end
                P_CMD: begin
                    rd_cnt <= '0;
                    pstate <= P_READ;
                end
                P_READ: begin
                    if (stat_ready) begin
                        pass_q <= ~stat_fail;
                        pstate <= P_DONE;
                    end else if (rd_cnt == LAST_READ) begin
                        pass_q <= 1'b0;
                        pstate <= P_DONE;
                    end else begin
                        rd_cnt <= rd_cnt + 1'b1;
                    end
                end
                P_DONE: begin
                    pstate <= go ? P_CMD : P_IDLE;
                end
                default: pstate <= P_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd_we   = 1'b0;
        rd_en    = 1'b0;
        done     = 1'b0;
        cmd_byte = '0;
        unique case (pstate)
            P_CMD: begin
                cmd_we   = 1'b1;
                cmd_byte = OP_STATUS;
            end
            P_READ: rd_en = 1'b1;
            P_DONE: done  = 1'b1;
            default: ;
        endcase
        owns_bus = cmd_we | rd_en;
        pass     = pass_q;
    end

endmodule

// File: rtl/onfi_field_capture.sv
module onfi_field_capture
    import onfi_probe_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             cap_en,
    input  logic [IDX_W-1:0] cap_idx,
    input  logic [7:0]       cap_byte,
    input  logic             commit,
    output logic             any_data,
    output logic [7:0]       mfr_id,
    output logic             bus_x16,
    output logic [31:0]      page_bytes,
    output logic [15:0]      spare_bytes,
    output logic [31:0]      pages_per_blk,
    output logic [31:0]      blks_per_lun,
    output logic [7:0]       lun_count,
    output logic [7:0]       ecc_bits,
    output logic [7:0]       model_code
);

    logic        nonff_q;
    logic [7:0]  sh_mfr, sh_luns, sh_ecc, sh_model;
    logic        sh_width;
    logic [31:0] sh_page, sh_ppb, sh_bpl;
    logic [15:0] sh_spare;

    // Shadow capture: each byte lands in its field as it streams past
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nonff_q  <= 1'b0;
            sh_mfr   <= '0;
            sh_luns  <= '0;
            sh_ecc   <= '0;
            sh_model <= '0;
            sh_width <= 1'b0;
            sh_page  <= '0;
            sh_ppb   <= '0;
            sh_bpl   <= '0;
            sh_spare <= '0;
        end else if (clear) begin
            nonff_q <= 1'b0;
        end else if (cap_en) begin
            if (cap_byte != 8'hFF) nonff_q <= 1'b1;
            if (cap_idx == IDX_W'(OFF_WIDTH)) sh_width <= cap_byte[0];
            if (cap_idx == IDX_W'(OFF_MODEL)) sh_model <= cap_byte;
            if (cap_idx == IDX_W'(OFF_MFR))   sh_mfr   <= cap_byte;
            if (cap_idx == IDX_W'(OFF_LUNS))  sh_luns  <= cap_byte;
            if (cap_idx == IDX_W'(OFF_ECC))   sh_ecc   <= cap_byte;
            for (int k = 0; k < 4; k++) begin
                if (cap_idx == IDX_W'(OFF_PAGE + k)) sh_page[8*k +: 8] <= cap_byte;
                if (cap_idx == IDX_W'(OFF_PPB + k))  sh_ppb[8*k +: 8]  <= cap_byte;
                if (cap_idx == IDX_W'(OFF_BPL + k))  sh_bpl[8*k +: 8]  <= cap_byte;
            end
            for (int k = 0; k < 2; k++) begin
                if (cap_idx == IDX_W'(OFF_SPARE + k)) sh_spare[8*k +: 8] <= cap_byte;
            end
        end
    end

    // Visible fields move only on a successful probe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mfr_id        <= '0;
            bus_x16       <= 1'b0;
            page_bytes    <= '0;
            spare_bytes   <= '0;
            pages_per_blk <= '0;
            blks_per_lun  <= '0;
            lun_count     <= '0;
            ecc_bits      <= '0;
            model_code    <= '0;
        end else if (commit) begin
            mfr_id        <= sh_mfr;
            bus_x16       <= sh_width;
            page_bytes    <= sh_page;
            spare_bytes   <= sh_spare;
            pages_per_blk <= sh_ppb;
            blks_per_lun  <= sh_bpl;
            lun_count     <= sh_luns;
            ecc_bits      <= sh_ecc;
            model_code    <= sh_model;
        end
    end

    assign any_data = nonff_q;

endmodule

// File: rtl/onfi_probe.sv
module onfi_probe
    import onfi_probe_pkg::*;
#(
    parameter int PROBE_TRIES = 60,
    parameter int POLL_READS  = 64,
    parameter int PARAM_BYTES = 116
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic        busy,
    output logic        done,
    output logic        found,
    output logic [1:0]  err_code,
    output logic        nand_cle,
    output logic        nand_ale,
    output logic        nand_we,
    output logic        nand_re,
    output logic [7:0]  nand_dout,
    input  logic [7:0]  nand_din,
    output logic [7:0]  mfr_id,
    output logic        bus_x16,
    output logic [31:0] page_bytes,
    output logic [15:0] spare_bytes,
    output logic [31:0] pages_per_blk,
    output logic [31:0] blks_per_lun,
    output logic [7:0]  lun_count,
    output logic [7:0]  ecc_bits,
    output logic [7:0]  model_code
);

    localparam int IDX_RAW = $clog2(PARAM_BYTES);
    localparam int IDX_W   = (IDX_RAW < 2) ? 2 : IDX_RAW;
    localparam int TRY_W   = $clog2(PROBE_TRIES + 1);
    localparam logic [TRY_W-1:0] LAST_TRY  = TRY_W'(PROBE_TRIES - 1);
    localparam logic [IDX_W-1:0] LAST_BYTE = IDX_W'(PARAM_BYTES - 1);
    localparam logic [IDX_W-1:0] LAST_SIG  = IDX_W'(3);

    seq_state_e       state;
    logic [TRY_W-1:0] tries;
    logic [IDX_W-1:0] idx;
    logic             sig_bad;
    probe_err_e       err_q;
    logic             found_q;

    logic       poll_go, poll_owns, poll_we, poll_re, poll_done, poll_pass;
    logic [7:0] poll_byte;
    logic       seq_cle, seq_ale, seq_we, seq_re;
    logic [7:0] seq_dout;
    logic       cap_clear, cap_en, commit, any_data;
    logic       sig_miss;

    onfi_status_poll #(.POLL_READS(POLL_READS)) u_poll (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (poll_go),
        .stat_ready (nand_din[STAT_READY_BIT]),
        .stat_fail  (nand_din[STAT_FAIL_BIT]),
        .owns_bus   (poll_owns),
        .cmd_we     (poll_we),
        .rd_en      (poll_re),
        .cmd_byte   (poll_byte),
        .done       (poll_done),
        .pass       (poll_pass)
    );

    onfi_field_capture #(.IDX_W(IDX_W)) u_fields (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear         (cap_clear),
        .cap_en        (cap_en),
        .cap_idx       (idx),
        .cap_byte      (nand_din),
        .commit        (commit),
        .any_data      (any_data),
        .mfr_id        (mfr_id),
        .bus_x16       (bus_x16),
        .page_bytes    (page_bytes),
        .spare_bytes   (spare_bytes),
        .pages_per_blk (pages_per_blk),
        .blks_per_lun  (blks_per_lun),
        .lun_count     (lun_count),
        .ecc_bits      (ecc_bits),
        .model_code    (model_code)
    );

    assign sig_miss = (nand_din != sig_char(idx[1:0]));

    // State register and sequencing data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            tries   <= '0;
            idx     <= '0;
            sig_bad <= 1'b0;
            err_q   <= ERR_NONE;
            found_q <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        tries <= '0;
                        state <= S_RESET;
                    end
                end
                S_RESET: state <= S_PROBE;
                S_PROBE: begin
                    if (poll_done) begin
                        if (poll_pass) begin
                            state <= S_SIG_CMD;
                        end else if (tries == LAST_TRY) begin
                            err_q   <= ERR_NODEV;
                            found_q <= 1'b0;
                            state   <= S_FINISH;
                        end else begin
                            tries <= tries + 1'b1;
                        end
                    end
                end
                S_SIG_CMD: state <= S_SIG_ADDR;
                S_SIG_ADDR: begin
                    idx     <= '0;
                    sig_bad <= 1'b0;
                    state   <= S_SIG_READ;
                end
                S_SIG_READ: begin
                    idx <= idx + 1'b1;
                    if (sig_miss) sig_bad <= 1'b1;
                    if (idx == LAST_SIG) begin
                        if (sig_bad || sig_miss) begin
                            err_q   <= ERR_NODEV;
                            found_q <= 1'b0;
                            state   <= S_FINISH;
                        end else begin
                            state <= S_PRM_CMD;
                        end
                    end
                end
                S_PRM_CMD:  state <= S_PRM_ADDR;
                S_PRM_ADDR: state <= S_PRM_WAIT;
                S_PRM_WAIT: begin
                    if (poll_done) state <= S_PRM_DOUT;
                end
                S_PRM_DOUT: begin
                    idx   <= '0;
                    state <= S_PRM_READ;
                end
                S_PRM_READ: begin
                    idx <= idx + 1'b1;
                    if (idx == LAST_BYTE) state <= S_CHECK;
                end
                S_CHECK: begin
                    err_q   <= any_data ? ERR_NONE : ERR_IO;
                    found_q <= any_data;
                    state   <= S_FINISH;
                end
                S_FINISH: state <= S_IDLE;
                default:  state <= S_IDLE;
            endcase
        end
    end

    // Per-state outputs
    always_comb begin
        seq_cle   = 1'b0;
        seq_ale   = 1'b0;
        seq_we    = 1'b0;
        seq_re    = 1'b0;
        seq_dout  = '0;
        poll_go   = 1'b0;
        cap_clear = 1'b0;
        cap_en    = 1'b0;
        commit    = 1'b0;
        done      = 1'b0;
        unique case (state)
            S_RESET: begin
                seq_cle  = 1'b1;
                seq_we   = 1'b1;
                seq_dout = OP_RESET;
                poll_go  = 1'b1;
            end
            S_PROBE: poll_go = poll_done && !poll_pass && (tries != LAST_TRY);
            S_SIG_CMD: begin
                seq_cle  = 1'b1;
                seq_we   = 1'b1;
                seq_dout = OP_READ_ID;
            end
            S_SIG_ADDR: begin
                seq_ale  = 1'b1;
                seq_we   = 1'b1;
                seq_dout = ADDR_SIG;
            end
            S_SIG_READ: seq_re = 1'b1;
            S_PRM_CMD: begin
                seq_cle  = 1'b1;
                seq_we   = 1'b1;
                seq_dout = OP_PARAM;
            end
            S_PRM_ADDR: begin
                seq_ale  = 1'b1;
                seq_we   = 1'b1;
                seq_dout = ADDR_PARAM;
                poll_go  = 1'b1;
            end
            S_PRM_DOUT: begin
                seq_cle   = 1'b1;
                seq_we    = 1'b1;
                seq_dout  = OP_DATA_OUT;
                cap_clear = 1'b1;
            end
            S_PRM_READ: begin
                seq_re = 1'b1;
                cap_en = 1'b1;
            end
            S_CHECK:  commit = any_data;
            S_FINISH: done   = 1'b1;
            default: ;
        endcase
    end

    // Bus ownership: the poll engine drives while it is active
    assign nand_cle  = poll_owns ? poll_we   : seq_cle;
    assign nand_ale  = poll_owns ? 1'b0      : seq_ale;
    assign nand_we   = poll_owns ? poll_we   : seq_we;
    assign nand_re   = poll_owns ? poll_re   : seq_re;
    assign nand_dout = poll_owns ? poll_byte : seq_dout;

    assign busy     = (state != S_IDLE);
    assign found    = found_q;
    assign err_code = err_q;

endmodule

// File: rtl/onfi_probe_chk.sv
module onfi_probe_chk #(
    parameter int POLL_READS = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       found,
    input logic [1:0] err_code,
    input logic       nand_cle,
    input logic       nand_ale,
    input logic       nand_we,
    input logic       nand_re,
    input logic [7:0] nand_dout
);

    localparam int CW = $clog2(POLL_READS + 2) + 1;

    logic          in_status;
    logic [CW-1:0] stat_reads;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_status  <= 1'b0;
            stat_reads <= '0;
        end else if (nand_we) begin
            in_status  <= nand_cle && (nand_dout == 8'h70);
            stat_reads <= '0;
        end else if (nand_re && in_status) begin
            stat_reads <= stat_reads + 1'b1;
        end
    end

    // R2
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_we && nand_re));

    // R2
    latch_needs_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nand_cle || nand_ale) |-> nand_we);

    // R2
    cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(nand_we || nand_re));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    found_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (err_code == 2'b00));

    // R4
    err_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_code != 2'b11);

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    // R12
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_reads <= CW'(POLL_READS));

endmodule

bind onfi_probe onfi_probe_chk #(.POLL_READS(POLL_READS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .found     (found),
    .err_code  (err_code),
    .nand_cle  (nand_cle),
    .nand_ale  (nand_ale),
    .nand_we   (nand_we),
    .nand_re   (nand_re),
    .nand_dout (nand_dout)
);

// File: tb/onfi_probe_bench.sv
`timescale 1ns/1ps
module onfi_probe_bench;

    localparam int POLL_READS = 64;

    typedef struct packed {
        logic [7:0] fails;
        logic [7:0] busyr;
        logic       dead;
        logic       sigbad;
        logic       allff;
        logic [7:0] seed;
        logic [1:0] err;
        logic [7:0] nstat;
    } vec_t;

    localparam vec_t VECS [0:7] = '{
        '{8'd0,  8'd0,  1'b0, 1'b0, 1'b0, 8'd1, 2'b00, 8'd2},
        '{8'd3,  8'd5,  1'b0, 1'b0, 1'b0, 8'd2, 2'b00, 8'd5},
        '{8'd59, 8'd1,  1'b0, 1'b0, 1'b0, 8'd3, 2'b00, 8'd61},
        '{8'd60, 8'd0,  1'b0, 1'b0, 1'b0, 8'd4, 2'b01, 8'd60},
        '{8'd0,  8'd0,  1'b1, 1'b0, 1'b0, 8'd5, 2'b01, 8'd60},
        '{8'd0,  8'd0,  1'b0, 1'b1, 1'b0, 8'd6, 2'b01, 8'd1},
        '{8'd2,  8'd0,  1'b0, 1'b0, 1'b1, 8'd7, 2'b10, 8'd4},
        '{8'd0,  8'd63, 1'b0, 1'b0, 1'b0, 8'd8, 2'b00, 8'd2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic busy, done, found, bus_x16;
    logic [1:0]  err_code;
    logic        nand_cle, nand_ale, nand_we, nand_re;
    logic [7:0]  nand_dout, nand_din;
    logic [7:0]  mfr_id, lun_count, ecc_bits, model_code;
    logic [31:0] page_bytes, pages_per_blk, blks_per_lun;
    logic [15:0] spare_bytes;

    always #2 clk = ~clk;

    onfi_probe u_onfi_probe (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .found(found), .err_code(err_code), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we(nand_we), .nand_re(nand_re),
        .nand_dout(nand_dout), .nand_din(nand_din), .mfr_id(mfr_id),
        .bus_x16(bus_x16), .page_bytes(page_bytes), .spare_bytes(spare_bytes),
        .pages_per_blk(pages_per_blk), .blks_per_lun(blks_per_lun),
        .lun_count(lun_count), .ecc_bits(ecc_bits), .model_code(model_code)
    );

    // ---------------- device model ----------------
    localparam logic [2:0] M_NONE = 3'd0, M_STAT = 3'd1, M_IDPEND = 3'd2,
                           M_ID = 3'd3, M_PARAM = 3'd4;

    logic       clr = 1'b0;
    logic [7:0] cfg_fails = 8'd0, cfg_busy = 8'd0, cfg_seed = 8'd0;
    logic       cfg_dead = 1'b0, cfg_sigbad = 1'b0, cfg_allff = 1'b0;

    logic [2:0] mode;
    logic [7:0] ptr, busy_left, fails_left;
    logic       ec_seen, stat_after_ec;
    int n_reset, n_status, n_readid, n_param, n_ec, cur_st, max_st;

    function automatic logic [7:0] pbyte(input logic [7:0] s, input logic [7:0] i);
        case (i)
            8'd6:   pbyte = {7'h0A, s[0]};
            8'd49:  pbyte = 8'h30 + s;
            8'd64:  pbyte = 8'h2C ^ s;
            8'd80:  pbyte = s ^ 8'h3C;
            8'd81:  pbyte = 8'h08;
            8'd82:  pbyte = 8'hA5;
            8'd83:  pbyte = s;
            8'd84:  pbyte = 8'h40;
            8'd85:  pbyte = s;
            8'd92:  pbyte = 8'h40;
            8'd93:  pbyte = 8'h01;
            8'd94:  pbyte = s;
            8'd95:  pbyte = 8'h00;
            8'd96:  pbyte = s;
            8'd97:  pbyte = 8'h04;
            8'd98:  pbyte = 8'h00;
            8'd99:  pbyte = 8'h01 ^ s;
            8'd100: pbyte = s + 8'd1;
            8'd112: pbyte = s + 8'd4;
            default: pbyte = i ^ 8'h5A;
        endcase
    endfunction

    function automatic logic [7:0] sigb(input logic [7:0] p, input logic bad);
        case (p)
            8'd0: sigb = 8'h4F;
            8'd1: sigb = 8'h4E;
            8'd2: sigb = bad ? 8'h58 : 8'h46;
            8'd3: sigb = 8'h49;
            default: sigb = 8'h00;
        endcase
    endfunction

    always_comb begin
        case (mode)
            M_STAT:  nand_din = (cfg_dead || busy_left != 8'd0) ? 8'h00 :
                                ((fails_left != 8'd0) ? 8'h41 : 8'h40);
            M_ID:    nand_din = sigb(ptr, cfg_sigbad);
            M_PARAM: nand_din = cfg_allff ? 8'hFF : pbyte(cfg_seed, ptr);
            default: nand_din = 8'hFF;
        endcase
    end

    always @(posedge clk) begin
        if (clr) begin
            mode <= M_NONE; ptr <= 8'd0; busy_left <= 8'd0;
            fails_left <= cfg_fails; ec_seen <= 1'b0; stat_after_ec <= 1'b0;
            n_reset <= 0; n_status <= 0; n_readid <= 0; n_param <= 0;
            n_ec <= 0; cur_st <= 0; max_st <= 0;
        end else if (nand_we && nand_cle) begin
            case (nand_dout)
                8'hFF: begin n_reset <= n_reset + 1; mode <= M_NONE; end
                8'h70: begin
                    mode <= M_STAT; busy_left <= cfg_busy;
                    n_status <= n_status + 1; cur_st <= 0;
                    if (ec_seen) stat_after_ec <= 1'b1;
                end
                8'h90: begin mode <= M_IDPEND; n_readid <= n_readid + 1; end
                8'hEC: begin
                    mode <= M_NONE; ec_seen <= 1'b1; stat_after_ec <= 1'b0;
                    n_ec <= n_ec + 1;
                end
                8'h00: begin
                    mode <= (ec_seen && stat_after_ec) ? M_PARAM : M_NONE;
                    ptr <= 8'd0;
                end
                default: mode <= M_NONE;
            endcase
        end else if (nand_we && nand_ale) begin
            if (mode == M_IDPEND && nand_dout == 8'h20) begin
                mode <= M_ID; ptr <= 8'd0;
            end else if (!(ec_seen && nand_dout == 8'h00)) begin
                mode <= M_NONE;
            end
        end else if (nand_re) begin
            case (mode)
                M_STAT: begin
                    cur_st <= cur_st + 1;
                    if (cur_st + 1 > max_st) max_st <= cur_st + 1;
                    if (!cfg_dead) begin
                        if (busy_left != 8'd0) busy_left <= busy_left - 8'd1;
                        else if (fails_left != 8'd0) fails_left <= fails_left - 8'd1;
                    end
                end
                M_ID: ptr <= ptr + 8'd1;
                M_PARAM: begin ptr <= ptr + 8'd1; n_param <= n_param + 1; end
                default: ;
            endcase
        end
    end

    // ---------------- checking ----------------
    int n_chk = 0, n_bad = 0, cyc = 0;
    logic finished = 1'b0;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000 && !finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
        end
    end

    logic [7:0]  ex_mfr = 8'd0, ex_luns = 8'd0, ex_ecc = 8'd0, ex_model = 8'd0;
    logic        ex_w = 1'b0;
    logic [31:0] ex_page = 32'd0, ex_ppb = 32'd0, ex_bpl = 32'd0;
    logic [15:0] ex_spare = 16'd0;

    task automatic prep(input vec_t v);
        @(negedge clk);
        cfg_fails = v.fails; cfg_busy = v.busyr; cfg_dead = v.dead;
        cfg_sigbad = v.sigbad; cfg_allff = v.allff; cfg_seed = v.seed;
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic wait_done(output logic ok);
        ok = 1'b0;
        for (int t = 0; t < 20000; t++) begin
            @(negedge clk);
            if (done) begin ok = 1'b1; break; end
        end
    endtask

    task automatic check_fields(input string tag);
        chk(mfr_id == ex_mfr,         {tag, " R9 mfr"},   32'(mfr_id), 32'(ex_mfr));
        chk(bus_x16 == ex_w,          {tag, " R9 width"}, 32'(bus_x16), 32'(ex_w));
        chk(page_bytes == ex_page,    {tag, " R9 page"},  page_bytes, ex_page);
        chk(spare_bytes == ex_spare,  {tag, " R9 spare"}, 32'(spare_bytes), 32'(ex_spare));
        chk(pages_per_blk == ex_ppb,  {tag, " R9 ppb"},   pages_per_blk, ex_ppb);
        chk(blks_per_lun == ex_bpl,   {tag, " R9 bpl"},   blks_per_lun, ex_bpl);
        chk(lun_count == ex_luns,     {tag, " R9 luns"},  32'(lun_count), 32'(ex_luns));
        chk(ecc_bits == ex_ecc,       {tag, " R9 ecc"},   32'(ecc_bits), 32'(ex_ecc));
        chk(model_code == ex_model,   {tag, " R9 model"}, 32'(model_code), 32'(ex_model));
    endtask

    initial begin
        logic ok;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !found, "R1 flags", {29'd0, busy, done, found}, 32'd0);
        chk(err_code == 2'b00, "R1 err", 32'(err_code), 32'd0);
        chk(page_bytes == 32'd0 && mfr_id == 8'd0, "R1 fields", page_bytes, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!nand_we && !nand_re, "R1 idle bus", {30'd0, nand_we, nand_re}, 32'd0);

        for (int i = 0; i < 8; i++) begin
            vec_t v;
            logic probe_ok, sig_ok;
            v = VECS[i];
            probe_ok = (v.fails < 8'd60) && !v.dead;
            sig_ok = probe_ok && !v.sigbad;
            prep(v);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait_done(ok);
            chk(ok, $sformatf("vec%0d R10 done seen", i), 32'(ok), 32'd1);
            chk(err_code == v.err, $sformatf("vec%0d R4 R6 R8 err", i), 32'(err_code), 32'(v.err));
            chk(found == (v.err == 2'b00), $sformatf("vec%0d R10 found", i), 32'(found), 32'(v.err == 2'b00));
            chk(n_reset == 1, $sformatf("vec%0d R3 reset cmds", i), 32'(n_reset), 32'd1);
            chk(n_status == int'(v.nstat), $sformatf("vec%0d R5 status cmds", i), 32'(n_status), 32'(v.nstat));
            chk(n_readid == int'(probe_ok), $sformatf("vec%0d R4 readid cmds", i), 32'(n_readid), 32'(probe_ok));
            chk(n_ec == int'(sig_ok), $sformatf("vec%0d R6 param cmds", i), 32'(n_ec), 32'(sig_ok));
            chk(n_param == (sig_ok ? 116 : 0), $sformatf("vec%0d R7 param reads", i), 32'(n_param), sig_ok ? 32'd116 : 32'd0);
            chk(max_st <= POLL_READS, $sformatf("vec%0d R12 reads per poll", i), 32'(max_st), 32'(POLL_READS));
            if (v.dead)
                chk(max_st == POLL_READS, "R12 timeout length", 32'(max_st), 32'(POLL_READS));
            if (v.err == 2'b00) begin
                ex_w = v.seed[0]; ex_model = 8'h30 + v.seed; ex_mfr = 8'h2C ^ v.seed;
                ex_page = {v.seed, 8'hA5, 8'h08, v.seed ^ 8'h3C};
                ex_spare = {v.seed, 8'h40};
                ex_ppb = {8'h00, v.seed, 8'h01, 8'h40};
                ex_bpl = {8'h01 ^ v.seed, 8'h00, 8'h04, v.seed};
                ex_luns = v.seed + 8'd1; ex_ecc = v.seed + 8'd4;
            end
            check_fields($sformatf("vec%0d%s", i, v.allff ? " R8 kept" : ""));
            @(negedge clk);
            chk(!done && !busy, $sformatf("vec%0d R10 single pulse", i), {30'd0, done, busy}, 32'd0);
        end

        // R11: start while busy is ignored
        prep(VECS[1]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (8) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(ok);
        repeat (20) @(negedge clk);
        chk(n_reset == 1, "R11 no restart", 32'(n_reset), 32'd1);
        chk(!busy, "R11 idle after", 32'(busy), 32'd0);
        chk(err_code == 2'b00 && found, "R11 result", 32'(err_code), 32'd0);

        finished = 1'b1;
        summary();
    end

endmodule